// File: doc/BRIEF.md
# Signature Verifier Control Register File

This block is the register file that lets a processor drive a 256-bit elliptic-curve signature verification engine through a simple word-addressed register port. It keeps five 256-bit operands: the two public-key coordinates, the two signature halves and the message digest. Each operand is loaded as eight 32-bit words and is presented to the engine as one flat 256-bit vector. Alongside the operands it holds a version constant, a software-controlled active-low engine reset, a start register and a result register. Writing the start register fires a one-cycle start pulse. Reading the start register returns the engine busy flag.

Software first releases the engine reset. It then loads the operands, writes the start register, and polls the busy flag until it reads zero. Finally it reads the result bit. The port takes a write strobe with four byte enables. A read request is answered by a read-valid pulse that carries the data.

Top module: `sigv_regfile`

## Requirements
- R1: Word address 0x00 (byte offset 0x0000) reads the VERSION parameter, and writes to it have no effect.
- R2: Bit 0 at word address 0x01 (byte offset 0x0004) drives `eng_rst_n` and reads back in bit 0. A write with byte enable 0 set loads it from write-data bit 0.
- R3: A write to word address 0x04 (byte offset 0x0010) with byte enable 0 set, made while `eng_busy` is low, drives `eng_start` high for exactly the one cycle that follows the write. A read of this address returns `eng_busy` in bit 0.
- R4: A start write that arrives while `eng_busy` is high produces no start pulse.
- R5: Word address 0x05 (byte offset 0x0014) returns `eng_result` in bit 0 and ignores writes.
- R6: The operands sit at word addresses 0x08–0x0F (key x), 0x10–0x17 (key y), 0x18–0x1F (r), 0x20–0x27 (s) and 0x28–0x2F (digest). Every operand word can be both written and read.
- R7: Operands are little-endian. Word k of a group (address base+k) drives bits [32k+31:32k] of that group's engine output.
- R8: Byte enable bit j gates write-data bits [8j+7:8j]. Byte lanes whose enable is clear keep their old value.
- R9: `reg_rd_valid` is high exactly in the cycle after a cycle with `reg_rd_req` high, and `reg_rd_data` is valid in that same cycle. In every other cycle `reg_rd_valid` is low.
- R10: An unmapped address reads as zero, and a write to it changes no register or output.
- R11: After reset, every operand is zero, the engine reset bit is 0 (the engine is held in reset) and `eng_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Word address shared by reads and writes |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 32 | Write data |
| reg_wr_be | input | 4 | Byte enables, bit j for byte j |
| reg_rd_req | input | 1 | Read request |
| reg_rd_valid | output | 1 | Read data valid |
| reg_rd_data | output | 32 | Read data |
| eng_rst_n | output | 1 | Active-low engine reset |
| eng_start | output | 1 | One-cycle start pulse |
| eng_busy | input | 1 | Engine busy flag |
| eng_result | input | 1 | Verification result |
| eng_qx | output | 256 | Public key x operand |
| eng_qy | output | 256 | Public key y operand |
| eng_r | output | 256 | Signature r operand |
| eng_s | output | 256 | Signature s operand |
| eng_hash | output | 256 | Message digest operand |

## Verification
The bench sends a start write while the engine is still busy. A design that failed to gate start would send a second pulse and restart the stub. Partial byte-enable writes, including an enable of zero on the reset register, expose designs that write whole words and would change lanes that should hold. The bench compares all five flat operand outputs against word ordering, which catches a reversed (big-endian) assembly or a swapped group. Reads and writes to unmapped addresses, the version word and the result word check that these never alias into stored state or return stale data.

// File: rtl/sigv_pkg.sv
package sigv_pkg;
  localparam int DATA_W     = 32;
  localparam int BYTE_W     = 8;
  localparam int NUM_BYTES  = DATA_W / BYTE_W;
  localparam int NUM_OPND   = 5;
  localparam int OPND_WORDS = 8;
  localparam int OPND_W     = OPND_WORDS * DATA_W;
  localparam int GRP_W      = $clog2(NUM_OPND);
  localparam int IDX_W      = $clog2(OPND_WORDS);
  localparam int TOTAL_WORDS = NUM_OPND * OPND_WORDS;

  // Word addresses (byte offset / 4)
  localparam int WA_VERSION = 'h00;
  localparam int WA_ENGRST  = 'h01;
  localparam int WA_START   = 'h04;
  localparam int WA_RESULT  = 'h05;
  localparam int WA_OPND    = 'h08;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_VER,
    SEL_RST,
    SEL_START,
    SEL_RES,
    SEL_OPND
  } sel_e;

  typedef struct packed {
    sel_e             sel;
    logic [GRP_W-1:0] grp;
    logic [IDX_W-1:0] idx;
  } dec_t;
endpackage

// File: rtl/sigv_addr_dec.sv
module sigv_addr_dec
  import sigv_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'(WA_VERSION);
  localparam logic [ADDR_W-1:0] A_RST   = ADDR_W'(WA_ENGRST);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(WA_START);
  localparam logic [ADDR_W-1:0] A_RES   = ADDR_W'(WA_RESULT);
  localparam logic [ADDR_W-1:0] A_OLO   = ADDR_W'(WA_OPND);
  localparam logic [ADDR_W-1:0] A_OHI   = ADDR_W'(WA_OPND + TOTAL_WORDS);

  logic [ADDR_W-1:0] off;

  assign off = addr - A_OLO;

  always_comb begin
    dec     = '0;
    dec.sel = SEL_NONE;
    if (addr == A_VER) begin
      dec.sel = SEL_VER;
    end else if (addr == A_RST) begin
      dec.sel = SEL_RST;
    end else if (addr == A_START) begin
      dec.sel = SEL_START;
    end else if (addr == A_RES) begin
      dec.sel = SEL_RES;
    end else if (addr >= A_OLO && addr < A_OHI) begin
      dec.sel = SEL_OPND;
      dec.grp = off[IDX_W +: GRP_W];
      dec.idx = off[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/sigv_operand_bank.sv
module sigv_operand_bank
  import sigv_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [GRP_W-1:0]            wr_grp,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [NUM_BYTES-1:0]        wr_be,
  input  logic [GRP_W-1:0]            rd_grp,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [DATA_W-1:0]           rd_data,
  output logic [NUM_OPND*OPND_W-1:0]  opnd_flat
);
  logic [DATA_W-1:0] word_q [TOTAL_WORDS];

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_grp
    for (genvar w = 0; w < OPND_WORDS; w++) begin : g_word
      localparam int K = g * OPND_WORDS + w;
      logic              hit;
      logic [DATA_W-1:0] nxt;
      logic [DATA_W-1:0] q;

      assign hit = wr_en && (wr_grp == GRP_W'(g)) && (wr_idx == IDX_W'(w));

      for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
        assign nxt[b*BYTE_W +: BYTE_W] = wr_be[b] ? wr_data[b*BYTE_W +: BYTE_W]
                                                  : q[b*BYTE_W +: BYTE_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (hit) begin
          q <= nxt;
        end
      end

      assign word_q[K] = q;
      assign opnd_flat[g*OPND_W + w*DATA_W +: DATA_W] = q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < TOTAL_WORDS; k++) begin
      if ({rd_grp, rd_idx} == (GRP_W+IDX_W)'(((k / OPND_WORDS) << IDX_W) + (k % OPND_WORDS))) begin
        rd_data = word_q[k];
      end
    end
  end
endmodule

// File: rtl/sigv_ctrl.sv
module sigv_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_we,
  input  logic rst_wbit,
  input  logic start_we,
  input  logic busy,
  output logic eng_rst_n,
  output logic eng_start
);
  logic rst_bit_q, rst_bit_d;
  logic start_q, start_d;

  always_comb begin
    rst_bit_d = rst_we ? rst_wbit : rst_bit_q;
    start_d   = start_we && !busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_bit_q <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      rst_bit_q <= rst_bit_d;
      start_q   <= start_d;
    end
  end

  assign eng_rst_n = rst_bit_q;
  assign eng_start = start_q;
endmodule

// File: rtl/sigv_regfile.sv
module sigv_regfile
  import sigv_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter logic [31:0] VERSION = 32'h5A6E_0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [31:0]       reg_wr_data,
  input  logic [3:0]        reg_wr_be,
  input  logic              reg_rd_req,
  output logic              reg_rd_valid,
  output logic [31:0]       reg_rd_data,
  output logic              eng_rst_n,
  output logic              eng_start,
  input  logic              eng_busy,
  input  logic              eng_result,
  output logic [255:0]      eng_qx,
  output logic [255:0]      eng_qy,
  output logic [255:0]      eng_r,
  output logic [255:0]      eng_s,
  output logic [255:0]      eng_hash
);
  dec_t                       dec;
  logic [DATA_W-1:0]          opnd_rd;
  logic [NUM_OPND*OPND_W-1:0] opnd_flat;
  logic                       opnd_we;
  logic                       rst_we;
  logic                       start_we;
  logic [DATA_W-1:0]          rd_mux;
  logic [DATA_W-1:0]          rd_data_q;
  logic                       rd_valid_q;

  sigv_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (reg_addr),
    .dec  (dec)
  );

  assign opnd_we  = reg_wr_en && (dec.sel == SEL_OPND);
  assign rst_we   = reg_wr_en && (dec.sel == SEL_RST) && reg_wr_be[0];
  assign start_we = reg_wr_en && (dec.sel == SEL_START) && reg_wr_be[0];

  sigv_operand_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (opnd_we),
    .wr_grp    (dec.grp),
    .wr_idx    (dec.idx),
    .wr_data   (reg_wr_data),
    .wr_be     (reg_wr_be),
    .rd_grp    (dec.grp),
    .rd_idx    (dec.idx),
    .rd_data   (opnd_rd),
    .opnd_flat (opnd_flat)
  );

  sigv_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_we    (rst_we),
    .rst_wbit  (reg_wr_data[0]),
    .start_we  (start_we),
    .busy      (eng_busy),
    .eng_rst_n (eng_rst_n),
    .eng_start (eng_start)
  );

  always_comb begin
    rd_mux = '0;
    unique case (dec.sel)
      SEL_VER:   rd_mux = VERSION;
      SEL_RST:   rd_mux[0] = eng_rst_n;
      SEL_START: rd_mux[0] = eng_busy;
      SEL_RES:   rd_mux[0] = eng_result;
      SEL_OPND:  rd_mux = opnd_rd;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= reg_rd_req;
      if (reg_rd_req) begin
        rd_data_q <= rd_mux;
      end
    end
  end

  assign reg_rd_valid = rd_valid_q;
  assign reg_rd_data  = rd_data_q;

  assign eng_qx   = opnd_flat[0*OPND_W +: OPND_W];
  assign eng_qy   = opnd_flat[1*OPND_W +: OPND_W];
  assign eng_r    = opnd_flat[2*OPND_W +: OPND_W];
  assign eng_s    = opnd_flat[3*OPND_W +: OPND_W];
  assign eng_hash = opnd_flat[4*OPND_W +: OPND_W];
endmodule

// File: rtl/sigv_regfile_chk.sv
module sigv_regfile_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr_en,
  input logic [31:0]       reg_wr_data,
  input logic [3:0]        reg_wr_be,
  input logic              reg_rd_req,
  input logic              reg_rd_valid,
  input logic [31:0]       reg_rd_data,
  input logic              eng_rst_n,
  input logic              eng_start,
  input logic              eng_busy,
  input logic [255:0]      eng_qx,
  input logic [255:0]      eng_qy,
  input logic [255:0]      eng_r,
  input logic [255:0]      eng_s,
  input logic [255:0]      eng_hash
);
  localparam logic [ADDR_W-1:0] C_RST   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] C_START = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] C_QX0   = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] C_END   = ADDR_W'(48);

  logic unmapped;
  assign unmapped = !(reg_addr == ADDR_W'(0) || reg_addr == C_RST ||
                      reg_addr == C_START || reg_addr == ADDR_W'(5) ||
                      (reg_addr >= C_QX0 && reg_addr < C_END));

  p_rd_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_req |=> reg_rd_valid);

  p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_req |=> !reg_rd_valid);

  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_start_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(reg_wr_en && reg_addr == C_START && reg_wr_be[0] && !eng_busy));

  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == C_START && eng_busy) |=> !eng_start);

  p_rst_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_rst_n) |-> $past(reg_wr_en && reg_addr == C_RST && reg_wr_be[0] && reg_wr_data[0]));

  p_opnd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable({eng_qx, eng_qy, eng_r, eng_s, eng_hash}));

  p_word0_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == C_QX0 && reg_wr_be == 4'hF) |=> eng_qx[31:0] == $past(reg_wr_data));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_req && unmapped) |=> reg_rd_data == 32'h0);
endmodule

bind sigv_regfile sigv_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_sigv_regfile.sv
`timescale 1ns/1ps
module test_sigv_regfile;
  localparam int          AW  = 8;
  localparam logic [31:0] VER = 32'h5A6E_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [3:0] reg_wr_be = '0;
  logic reg_rd_req = 1'b0;
  logic reg_rd_valid;
  logic [31:0] reg_rd_data;
  logic eng_rst_n, eng_start;
  logic eng_busy, eng_result;
  logic [255:0] eng_qx, eng_qy, eng_r, eng_s, eng_hash;

  always #4 clk = ~clk;

  sigv_regfile #(.ADDR_W(AW), .VERSION(VER)) i_sigv_regfile (.*);

  // Behavioural engine stub: busy for 20 cycles, result = (r == s)
  int stub_cnt;
  always_ff @(posedge clk or negedge eng_rst_n) begin
    if (!eng_rst_n) begin
      eng_busy <= 1'b0; eng_result <= 1'b0; stub_cnt <= 0;
    end else if (eng_start) begin
      eng_busy <= 1'b1; eng_result <= (eng_r == eng_s); stub_cnt <= 20;
    end else if (stub_cnt > 1) begin
      stub_cnt <= stub_cnt - 1;
    end else begin
      eng_busy <= 1'b0; stub_cnt <= 0;
    end
  end

  int n_run = 0, n_fail = 0;
  logic [31:0] sh [48];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && reg_rd_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected valid", 256'(reg_rd_data), 256'(0));
      else begin
        logic [31:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(reg_rd_data == e, t, 256'(reg_rd_data), 256'(e));
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_addr = AW'(a); reg_wr_data = d; reg_wr_be = be; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (a >= 8 && a < 48)
      for (int b = 0; b < 4; b++) if (be[b]) sh[a-8][b*8 +: 8] = d[b*8 +: 8];
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_addr = AW'(a); reg_rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd_req = 1'b0;
  endtask

  function automatic logic [255:0] grp_val(input int g);
    logic [255:0] v;
    for (int w = 0; w < 8; w++) v[w*32 +: 32] = sh[g*8 + w];
    return v;
  endfunction

  task automatic chk_flat(input string t);
    chk(eng_qx   == grp_val(0), {t, " qx"},   eng_qx,   grp_val(0));
    chk(eng_qy   == grp_val(1), {t, " qy"},   eng_qy,   grp_val(1));
    chk(eng_r    == grp_val(2), {t, " r"},    eng_r,    grp_val(2));
    chk(eng_s    == grp_val(3), {t, " s"},    eng_s,    grp_val(3));
    chk(eng_hash == grp_val(4), {t, " hash"}, eng_hash, grp_val(4));
  endtask

  task automatic run_verify(input bit exp_res);
    wr(4, 32'h1, 4'h1);
    chk(eng_start == 1'b1, "R3 start pulse high", 256'(eng_start), 256'(1));
    @(negedge clk);
    chk(eng_start == 1'b0, "R3 start pulse one cycle", 256'(eng_start), 256'(0));
    rd(4, 32'h1, "R3 busy readback");
    wr(4, 32'h1, 4'hF);
    chk(eng_start == 1'b0, "R4 start while busy", 256'(eng_start), 256'(0));
    @(negedge clk);
    chk(eng_start == 1'b0, "R4 start while busy later", 256'(eng_start), 256'(0));
    repeat (30) @(negedge clk);
    rd(4, 32'h0, "R3 busy cleared");
    rd(5, {31'b0, exp_res}, "R5 result");
  endtask

  bit done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 48; i++) sh[i] = '0;
    repeat (3) @(negedge clk);
    chk(eng_rst_n == 1'b0, "R11 engine reset held", 256'(eng_rst_n), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(eng_start == 1'b0, "R11 start low", 256'(eng_start), 256'(0));
    chk(reg_rd_valid == 1'b0, "R9 idle valid low", 256'(reg_rd_valid), 256'(0));
    chk_flat("R11 operands zero");

    rd(0, VER, "R1 version");
    wr(0, 32'hFFFF_FFFF, 4'hF);
    rd(0, VER, "R1 version after write");

    rd(1, 32'h0, "R11 reset bit zero");
    wr(1, 32'h1, 4'hE);
    chk(eng_rst_n == 1'b0, "R8 reset bit lane disabled", 256'(eng_rst_n), 256'(0));
    wr(1, 32'h1, 4'h1);
    chk(eng_rst_n == 1'b1, "R2 engine reset released", 256'(eng_rst_n), 256'(1));
    rd(1, 32'h1, "R2 reset bit readback");

    for (int a = 8; a < 48; a++)
      wr(a, {8'(a), 8'hC3, 8'(a + 1), 8'h5A}, 4'hF);
    chk_flat("R7 little-endian assembly");
    for (int a = 8; a < 48; a += 7) rd(a, sh[a-8], "R6 operand readback");
    rd(47, sh[39], "R6 last digest word");

    wr(19, 32'h1122_3344, 4'b0101);
    rd(19, sh[11], "R8 partial byte write");
    chk_flat("R8 flat after partial write");

    rd(6, 32'h0, "R10 gap read");
    rd(48, 32'h0, "R10 above operands read");
    wr(48, 32'hDEAD_BEEF, 4'hF);
    wr(255, 32'hDEAD_BEEF, 4'hF);
    rd(48, 32'h0, "R10 read after write");
    rd(255, 32'h0, "R10 top address read");
    chk_flat("R10 operands unchanged");

    run_verify(1'b0);
    for (int w = 0; w < 8; w++) wr(32 + w, sh[16 + w], 4'hF);
    run_verify(1'b1);
    wr(5, 32'h0, 4'hF);
    rd(5, 32'h1, "R5 result ignores write");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all reads answered", 256'(exp_q.size()), 256'(0));
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule